// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the control decoder of a simple load/store processor core. A 6-bit opcode enters a main decoder that produces the datapath steering and enable signals. These cover the destination register select, the register write enable, the ALU second-operand select, the memory read and write enables, the memory-to-register select, the branch and jump flags, and a 2-bit ALU class. A second decoder combines that 2-bit class with the 6-bit function field of register-format instructions and produces the 4-bit operation code for the ALU.

Both decoders are purely combinational. Each is built as an explicit programmable-logic-array structure. An AND plane forms one product term per recognised input pattern. An OR plane then collects selected terms onto each output. The contents of both planes are parameters of one shared array module. An opcode that matches no product term leaves every output low, so it changes no architectural state.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register format) drives reg_dst=1, reg_write=1, alu_op=10 and every other control output 0.
- R2: Opcode 100011 (load) drives alu_src=1, mem_read=1, mem_to_reg=1, reg_write=1, alu_op=00 and every other control output 0.
- R3: Opcode 101011 (store) drives alu_src=1, mem_write=1, alu_op=00 and every other control output 0.
- R4: Opcode 000100 (branch if equal) drives branch=1, alu_op=01 and every other control output 0.
- R5: Opcode 000010 (jump) drives jump=1, alu_op=00 and every other control output 0.
- R6: Any other opcode drives all ten control outputs to 0, including alu_op=00.
- R7: With alu_op=00, alu_ctl is 0010 (add) whatever the function field holds.
- R8: With alu_op=01, alu_ctl is 0110 (subtract) whatever the function field holds.
- R9: With alu_op bit 1 set, the function field selects alu_ctl: 100000 gives 0010 (add), 100010 gives 0110 (subtract), 100100 gives 0000 (AND), 100101 gives 0001 (OR), 101010 gives 0111 (set-less-than), 100111 gives 1100 (NOR).
- R10: With alu_op bit 1 set and any other function field value, alu_ctl is 0000.
- R11: mem_read and mem_write are never high together, and reg_dst high implies reg_write high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Function field of register-format instructions |
| reg_dst | output | 1 | Destination register taken from the third register field |
| alu_src | output | 1 | ALU second operand taken from the extended immediate |
| mem_to_reg | output | 1 | Register write data taken from memory |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch instruction |
| jump | output | 1 | Unconditional jump; selects the jump target for the PC |
| alu_op | output | 2 | ALU class passed from the main to the second decoder |
| alu_ctl | output | 4 | ALU operation code |

## Verification
The embedded checks assume that the opcode and function inputs are fully driven two-state values that settle before they are evaluated. They also assume that alu_op reaches the second decoder only from the main decoder, so the class 11 never appears at that decoder. The stimulus keeps to these conditions. It changes both fields together on one clock edge and samples half a period later. It then sweeps every one of the 4096 opcode and function combinations, so every product term, every unmatched pattern and every don't-care position is exercised.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int AOP_W  = 2;
    localparam int ALUC_W = 4;

    localparam logic [OP_W-1:0] OPC_RFMT  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;
    localparam logic [FN_W-1:0] FN_NOR = 6'b100111;

    localparam logic [ALUC_W-1:0] ALU_AND = 4'b0000;
    localparam logic [ALUC_W-1:0] ALU_OR  = 4'b0001;
    localparam logic [ALUC_W-1:0] ALU_ADD = 4'b0010;
    localparam logic [ALUC_W-1:0] ALU_SUB = 4'b0110;
    localparam logic [ALUC_W-1:0] ALU_SLT = 4'b0111;
    localparam logic [ALUC_W-1:0] ALU_NOR = 4'b1100;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADDR = 2'b00,
        AOP_CMP  = 2'b01,
        AOP_FUNC = 2'b10
    } aop_e;

    typedef struct packed {
        logic              reg_dst;
        logic              alu_src;
        logic              mem_to_reg;
        logic              reg_write;
        logic              mem_read;
        logic              mem_write;
        logic              branch;
        logic              jump;
        logic [AOP_W-1:0]  alu_op;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return (op == OPC_RFMT) || (op == OPC_LOAD) || (op == OPC_STORE) ||
               (op == OPC_BEQ)  || (op == OPC_JMP);
    endfunction

endpackage

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_IN   = 6,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 4,
    parameter logic [N_TERM-1:0][N_IN-1:0]  CARE   = '0,
    parameter logic [N_TERM-1:0][N_IN-1:0]  MATCH  = '0,
    parameter logic [N_OUT-1:0][N_TERM-1:0] OR_MAP = '0
) (
    input  logic [N_IN-1:0]   in_bits,
    output logic [N_TERM-1:0] terms,
    output logic [N_OUT-1:0]  out_bits
);

    // AND plane: a term is high when every cared-for input bit equals its match bit
    for (genvar t = 0; t < N_TERM; t++) begin : g_and
        assign terms[t] = &(~((in_bits ^ MATCH[t]) & CARE[t]));
    end

    // OR plane: each output collects the terms selected by its map row
    for (genvar o = 0; o < N_OUT; o++) begin : g_or
        assign out_bits[o] = |(terms & OR_MAP[o]);
    end

endmodule

// File: rtl/main_ctrl_pla.sv
module main_ctrl_pla
    import idec_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);

    localparam int NT = 5;  // term order: 0 rfmt, 1 load, 2 store, 3 beq, 4 jump

    localparam logic [NT-1:0][OP_W-1:0] CARE  = {NT{{OP_W{1'b1}}}};
    localparam logic [NT-1:0][OP_W-1:0] MATCH = {OPC_JMP, OPC_BEQ, OPC_STORE, OPC_LOAD, OPC_RFMT};

    // rows from ctrl bit 9 (reg_dst) down to bit 0 (alu_op[0]); columns jump..rfmt
    localparam logic [CTRL_W-1:0][NT-1:0] OR_MAP = {
        5'b00001,   // reg_dst
        5'b00110,   // alu_src
        5'b00010,   // mem_to_reg
        5'b00011,   // reg_write
        5'b00010,   // mem_read
        5'b00100,   // mem_write
        5'b01000,   // branch
        5'b10000,   // jump
        5'b00001,   // alu_op[1]
        5'b01000    // alu_op[0]
    };

    logic [NT-1:0]     terms;
    logic [CTRL_W-1:0] raw;

    pla_array #(
        .N_IN   (OP_W),
        .N_TERM (NT),
        .N_OUT  (CTRL_W),
        .CARE   (CARE),
        .MATCH  (MATCH),
        .OR_MAP (OR_MAP)
    ) u_plane (
        .in_bits  (opcode),
        .terms    (terms),
        .out_bits (raw)
    );

    assign ctrl = ctrl_t'(raw);

    always_comb begin
        p_one_term_r6: assert ($onehot0(terms))
            else $error("main decoder matched more than one opcode term");
        p_class_r4: assert (!(ctrl.branch && ctrl.alu_op != AOP_CMP))
            else $error("branch without compare class");
    end

endmodule

// File: rtl/alu_ctrl_pla.sv
module alu_ctrl_pla
    import idec_pkg::*;
(
    input  logic [AOP_W-1:0]  alu_op,
    input  logic [FN_W-1:0]   funct,
    output logic [ALUC_W-1:0] alu_ctl
);

    localparam int NI = AOP_W + FN_W;
    localparam int NT = 8;  // 0 addr, 1 cmp, 2 add, 3 sub, 4 and, 5 or, 6 slt, 7 nor

    localparam logic [NI-1:0] C_CLASS = {{AOP_W{1'b1}}, {FN_W{1'b0}}};
    localparam logic [NI-1:0] C_FUNC  = {1'b1, 1'b0, {FN_W{1'b1}}};

    localparam logic [NT-1:0][NI-1:0] CARE = {
        C_FUNC, C_FUNC, C_FUNC, C_FUNC, C_FUNC, C_FUNC, C_CLASS, C_CLASS
    };
    localparam logic [NT-1:0][NI-1:0] MATCH = {
        {2'b10, FN_NOR}, {2'b10, FN_SLT}, {2'b10, FN_OR}, {2'b10, FN_AND},
        {2'b10, FN_SUB}, {2'b10, FN_ADD}, {2'b01, {FN_W{1'b0}}}, {2'b00, {FN_W{1'b0}}}
    };
    // rows alu_ctl[3]..alu_ctl[0]; columns nor..addr
    localparam logic [ALUC_W-1:0][NT-1:0] OR_MAP = {
        8'b10000000,
        8'b11001010,
        8'b01001111,
        8'b01100000
    };

    logic [NT-1:0] terms;

    pla_array #(
        .N_IN   (NI),
        .N_TERM (NT),
        .N_OUT  (ALUC_W),
        .CARE   (CARE),
        .MATCH  (MATCH),
        .OR_MAP (OR_MAP)
    ) u_plane (
        .in_bits  ({alu_op, funct}),
        .terms    (terms),
        .out_bits (alu_ctl)
    );

    always_comb begin
        p_one_term_r10: assert ($onehot0(terms))
            else $error("ALU decoder matched more than one term");
        p_addr_add_r7: assert (!(alu_op == AOP_ADDR && alu_ctl != ALU_ADD))
            else $error("address class did not give add");
        p_cmp_sub_r8: assert (!(alu_op == AOP_CMP && alu_ctl != ALU_SUB))
            else $error("compare class did not give subtract");
    end

endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
    import idec_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output logic       reg_dst,
    output logic       alu_src,
    output logic       mem_to_reg,
    output logic       reg_write,
    output logic       mem_read,
    output logic       mem_write,
    output logic       branch,
    output logic       jump,
    output logic [1:0] alu_op,
    output logic [3:0] alu_ctl
);

    ctrl_t ctrl;

    main_ctrl_pla u_main (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    alu_ctrl_pla u_alu (
        .alu_op  (ctrl.alu_op),
        .funct   (funct),
        .alu_ctl (alu_ctl)
    );

    assign reg_dst    = ctrl.reg_dst;
    assign alu_src    = ctrl.alu_src;
    assign mem_to_reg = ctrl.mem_to_reg;
    assign reg_write  = ctrl.reg_write;
    assign mem_read   = ctrl.mem_read;
    assign mem_write  = ctrl.mem_write;
    assign branch     = ctrl.branch;
    assign jump       = ctrl.jump;
    assign alu_op     = ctrl.alu_op;

    always_comb begin
        p_mem_excl_r11: assert (!(mem_read && mem_write))
            else $error("read and write enables together");
        p_dst_wr_r11: assert (!reg_dst || reg_write)
            else $error("destination select without write");
        p_unknown_quiet_r6: assert (op_known(opcode) ||
                                    !(reg_write || mem_write || mem_read || branch || jump))
            else $error("unknown opcode raised an enable");
        p_rfmt_class_r1: assert (!(opcode == OPC_RFMT && alu_op != AOP_FUNC))
            else $error("register format without function class");
    end

endmodule

// File: tb/sim_instr_ctrl_decoder.sv
module sim_instr_ctrl_decoder;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [5:0] opcode = '0;
    logic [5:0] funct  = '0;
    logic reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump;
    logic [1:0] alu_op;
    logic [3:0] alu_ctl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    instr_ctrl_decoder u0 (
        .opcode, .funct, .reg_dst, .alu_src, .mem_to_reg, .reg_write,
        .mem_read, .mem_write, .branch, .jump, .alu_op, .alu_ctl
    );

    // {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump}
    function automatic logic [7:0] exp_flags(input logic [5:0] op);
        case (op)
            6'd0:  return 8'b1001_0000;
            6'd35: return 8'b0111_1000;
            6'd43: return 8'b0100_0100;
            6'd4:  return 8'b0000_0010;
            6'd2:  return 8'b0000_0001;
            default: return 8'b0;
        endcase
    endfunction

    function automatic logic [1:0] exp_aop(input logic [5:0] op);
        if (op == 6'd0) return 2'd2;
        if (op == 6'd4) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [3:0] exp_ctl(input logic [1:0] aop, input logic [5:0] fn);
        if (aop == 2'd0) return 4'd2;
        if (aop == 2'd1) return 4'd6;
        case (fn)
            6'd32: return 4'd2;
            6'd34: return 4'd6;
            6'd36: return 4'd0;
            6'd37: return 4'd1;
            6'd42: return 4'd7;
            6'd39: return 4'd12;
            default: return 4'd0;
        endcase
    endfunction

    function automatic string op_req(input logic [5:0] op);
        case (op)
            6'd0:  return "R1";
            6'd35: return "R2";
            6'd43: return "R3";
            6'd4:  return "R4";
            6'd2:  return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic string ctl_req(input logic [1:0] aop, input logic [5:0] fn);
        if (aop == 2'd0) return "R7";
        if (aop == 2'd1) return "R8";
        if (fn inside {6'd32, 6'd34, 6'd36, 6'd37, 6'd42, 6'd39}) return "R9";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp,
                         input logic [5:0] op, input logic [5:0] fn);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b fn=%b actual=%h expected=%h", req, op, fn, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [5:0] fn);
        @(posedge clk);
        opcode <= op;
        funct  <= fn;
        @(negedge clk);
        check(op_req(op), {6'd0, reg_dst, alu_src, mem_to_reg, reg_write, mem_read,
              mem_write, branch, jump, alu_op}, {6'd0, exp_flags(op), exp_aop(op)}, op, fn);
        check(ctl_req(exp_aop(op), fn), {12'd0, alu_ctl},
              {12'd0, exp_ctl(exp_aop(op), fn)}, op, fn);
        // R11: enable consistency
        check("R11", {14'd0, mem_read & mem_write, reg_dst & ~reg_write}, 16'd0, op, fn);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // directed corners first
        apply(6'd0, 6'd42);   // R1 with set-less-than (R9)
        apply(6'd0, 6'd39);   // R9 NOR
        apply(6'd0, 6'd33);   // R10 unlisted function
        apply(6'd35, 6'd34);  // R2, R7 ignores sub function
        apply(6'd43, 6'd39);  // R3
        apply(6'd4, 6'd36);   // R4, R8 ignores AND function
        apply(6'd2, 6'd0);    // R5
        apply(6'd63, 6'd32);  // R6
        // exhaustive sweep
        for (int o = 0; o < 64; o++) begin
            for (int f = 0; f < 64; f++) begin
                apply(6'(o), 6'(f));
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule